// File: doc/BRIEF.md
# Power Mode Sequencing Controller

This block is the mode controller of a power-management device. It keeps the device in one of four modes (power-down, start-up, active, sleep) and decides when to move between them. Three wake sources of mixed polarity can start the device from power-down: a charger-present input, a main power key and a second power key. During start-up the block switches on four supply functions one after another. Each step is a timed enable, and the step must report good before the next one begins. After the last step the processor reset is released and the device is active.

While the device is up, a regulator flag is filtered over a programmable time. A sleep-request line moves the device between active and sleep. A watchdog fault, an overvoltage, a filtered regulator failure or a power-on reset sends the device straight back to power-down. All inputs are assumed to be synchronised to the clock already. The analog regulators, the comparators, charging and the register interface are outside this block.

Top module: `pwr_mode_seq`

## Requirements
- R1: `mode_o` encodes power-down as 0, start-up as 1, active as 2 and sleep as 3. After `rst_n` is released with `por_i` high, the mode is 0.
- R2: In power-down, any one of these starts the block on the next clock edge, whatever the levels of the other sources: a rising edge of `chg_i`, a falling edge of `key1_n_i`, or a rising edge of `key2_i`. Other transitions of these inputs do not wake the block.
- R3: In the first cycle after `por_i` goes low (and after `rst_n` release, which counts as the end of a power-on reset), a high level on `chg_i` is a wake. After that cycle, a steady high on `chg_i` is not a wake.
- R4: Start-up runs four steps of `STEP_CYC` cycles each, with `step_o` showing the index 0..3. The enables are cumulative and come on in this order: step 0 `ref_en_o`, step 1 adds `osc_en_o`, step 2 adds `sup_en_o`, step 3 adds `reg_en_o`. All four stay on in active and sleep.
- R5: In the last cycle of a step, the good flag for that step is sampled (step 0 `ref_good_i`, step 1 `osc_good_i`, step 2 `sup_good_i`, step 3 `reg_good_i`). If it is low, the block returns to power-down on the next edge.
- R6: During start-up, a high `uvp_i`, `ovp_i` or `cpu_tmo_i` returns the block to power-down on the next edge.
- R7: When step 3 passes, `rst_rel_o` rises and `mode_o` becomes active on the same edge, 4·`STEP_CYC` cycles after start-up was entered. `rst_rel_o` stays high in active and in sleep.
- R8: In active, `sleep_req_n_i` low moves the block to sleep. In sleep, `sleep_req_n_i` high returns it to active. The line has no effect in any other mode.
- R9: In active or sleep, if `reg_good_i` is low for more than `TMIN` consecutive cycles, the block returns to power-down. A low run of exactly `TMIN` cycles is tolerated.
- R10: A high `por_i` forces power-down on the next edge from any mode, and no wake is taken while it is high.
- R11: In active, a high `wdog_fault_i` or `ovp_i` forces power-down on the next edge. This takes priority over a sleep request in the same cycle.
- R12: In power-down, all four enables and `rst_rel_o` are low and `step_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Power-on reset flag, active high |
| chg_i | input | 1 | Charger present, wake on rising edge or on level at end of POR |
| key1_n_i | input | 1 | Main power key, wake on falling edge |
| key2_i | input | 1 | Second power key, wake on rising edge |
| ref_good_i | input | 1 | References good (step 0 check) |
| osc_good_i | input | 1 | Oscillator good (step 1 check) |
| sup_good_i | input | 1 | Voltage supervision good (step 2 check) |
| reg_good_i | input | 1 | Regulators above threshold (step 3 check, filtered when up) |
| uvp_i | input | 1 | Undervoltage flag |
| ovp_i | input | 1 | Overvoltage flag |
| cpu_tmo_i | input | 1 | Start-up processor timeout tick |
| sleep_req_n_i | input | 1 | Sleep request, active low |
| wdog_fault_i | input | 1 | Watchdog fault |
| ref_en_o | output | 1 | Reference enable |
| osc_en_o | output | 1 | Oscillator enable |
| sup_en_o | output | 1 | Supervision enable |
| reg_en_o | output | 1 | Regulator enable |
| step_o | output | 2 | Current sequencing step |
| rst_rel_o | output | 1 | Processor reset release |
| mode_o | output | 2 | Mode code |

## Verification
Two things can fall in the same cycle in active mode: a sleep request and a watchdog fault (or overvoltage). A directed case drops `sleep_req_n_i` and raises `wdog_fault_i` in one cycle, and the expected result is power-down, not sleep. A start-up step can also complete in the same cycle as a timeout tick, and there the timeout must win. The random phase toggles all of these lines independently, so both coincidences occur many times. A bench reference model computes the expected mode, enables, step and release for every cycle.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [1:0] {
    PM_OFF    = 2'd0,
    PM_START  = 2'd1,
    PM_ACTIVE = 2'd2,
    PM_SLEEP  = 2'd3
  } pm_mode_e;

  localparam int unsigned N_STEPS = 4;
  localparam int unsigned STEP_W  = $clog2(N_STEPS);

  // Cumulative enable pattern for a start-up step: bit0 ref, bit1 osc,
  // bit2 supervision, bit3 regulators.
  function automatic logic [N_STEPS-1:0] step_enables(input logic [STEP_W-1:0] idx);
    return N_STEPS'((5'd2 << idx) - 5'd1);
  endfunction

  function automatic logic mode_is_up(input pm_mode_e m);
    return (m == PM_ACTIVE) || (m == PM_SLEEP);
  endfunction

  // Filter expiry: a low run is a fault once it has lasted more than tmin.
  function automatic logic run_expired(input int unsigned prior_low, input int unsigned tmin);
    return prior_low >= tmin;
  endfunction

endpackage

// File: rtl/pwr_wake_det.sv
module pwr_wake_det (
  input  logic clk,
  input  logic rst_n,
  input  logic por_i,
  input  logic chg_i,
  input  logic key1_n_i,
  input  logic key2_i,
  output logic por_end_o,
  output logic wake_o
);

  logic por_q, chg_q, key1_q, key2_q;

  // Reset values chosen so that no edge is seen right after reset, and the
  // release of rst_n counts as the end of a power-on reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_q  <= 1'b1;
      chg_q  <= 1'b1;
      key1_q <= 1'b0;
      key2_q <= 1'b1;
    end else begin
      por_q  <= por_i;
      chg_q  <= chg_i;
      key1_q <= key1_n_i;
      key2_q <= key2_i;
    end
  end

  logic chg_rise, key1_fall, key2_rise, chg_lvl;

  assign por_end_o = por_q && !por_i;
  assign chg_rise  = chg_i && !chg_q;
  assign key1_fall = !key1_n_i && key1_q;
  assign key2_rise = key2_i && !key2_q;
  assign chg_lvl   = por_end_o && chg_i;

  assign wake_o = !por_i && (chg_lvl || chg_rise || key1_fall || key2_rise);

endmodule

// File: rtl/pwr_rail_filter.sv
module pwr_rail_filter #(
  parameter int unsigned TMIN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic good_i,
  output logic fault_o
);
  import pwr_seq_pkg::*;

  localparam int unsigned CW = $clog2(TMIN + 1);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (!arm_i || good_i) begin
      low_q <= '0;
    end else if (low_q != CW'(TMIN)) begin
      low_q <= low_q + 1'b1;
    end
  end

  assign fault_o = arm_i && !good_i && run_expired(int'(low_q), TMIN);

endmodule

// File: rtl/pwr_step_timer.sv
module pwr_step_timer #(
  parameter int unsigned STEP_CYC = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            run_i,
  output logic [pwr_seq_pkg::STEP_W-1:0]  step_o,
  output logic                            last_o
);
  import pwr_seq_pkg::*;

  localparam int unsigned CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

  logic [CW-1:0]     cnt_q;
  logic [STEP_W-1:0] step_q;

  assign last_o = (cnt_q == CW'(STEP_CYC - 1));
  assign step_o = step_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      step_q <= '0;
    end else if (last_o) begin
      cnt_q  <= '0;
      step_q <= step_q + 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int unsigned STEP_CYC = 16,
  parameter int unsigned TMIN     = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_i,
  input  logic       chg_i,
  input  logic       key1_n_i,
  input  logic       key2_i,
  input  logic       ref_good_i,
  input  logic       osc_good_i,
  input  logic       sup_good_i,
  input  logic       reg_good_i,
  input  logic       uvp_i,
  input  logic       ovp_i,
  input  logic       cpu_tmo_i,
  input  logic       sleep_req_n_i,
  input  logic       wdog_fault_i,
  output logic       ref_en_o,
  output logic       osc_en_o,
  output logic       sup_en_o,
  output logic       reg_en_o,
  output logic [1:0] step_o,
  output logic       rst_rel_o,
  output logic [1:0] mode_o
);
  import pwr_seq_pkg::*;

  pm_mode_e mode_q, mode_d;

  // Named internal events (observed by the checker)
  logic              wake_w, por_end_w;
  logic              step_last_w;
  logic [STEP_W-1:0] step_idx_w;
  logic              rail_fault_w;
  logic              start_abort_w;
  logic              step_bad_w;
  logic              start_done_w;
  logic              up_trip_w;
  logic [N_STEPS-1:0] good_vec_w;
  logic [N_STEPS-1:0] en_vec_w;

  pwr_wake_det u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .por_i     (por_i),
    .chg_i     (chg_i),
    .key1_n_i  (key1_n_i),
    .key2_i    (key2_i),
    .por_end_o (por_end_w),
    .wake_o    (wake_w)
  );

  pwr_step_timer #(.STEP_CYC(STEP_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (mode_q == PM_START),
    .step_o (step_idx_w),
    .last_o (step_last_w)
  );

  pwr_rail_filter #(.TMIN(TMIN)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm_i   (mode_is_up(mode_q)),
    .good_i  (reg_good_i),
    .fault_o (rail_fault_w)
  );

  assign good_vec_w    = {reg_good_i, sup_good_i, osc_good_i, ref_good_i};
  assign start_abort_w = uvp_i || ovp_i || cpu_tmo_i;
  assign step_bad_w    = step_last_w && !good_vec_w[step_idx_w];
  assign start_done_w  = step_last_w && good_vec_w[step_idx_w]
                         && (step_idx_w == STEP_W'(N_STEPS - 1));
  assign up_trip_w     = wdog_fault_i || ovp_i || rail_fault_w;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      PM_OFF: begin
        if (wake_w) mode_d = PM_START;
      end
      PM_START: begin
        if (start_abort_w || step_bad_w) mode_d = PM_OFF;
        else if (start_done_w)           mode_d = PM_ACTIVE;
      end
      PM_ACTIVE: begin
        if (up_trip_w)           mode_d = PM_OFF;
        else if (!sleep_req_n_i) mode_d = PM_SLEEP;
      end
      PM_SLEEP: begin
        if (rail_fault_w)       mode_d = PM_OFF;
        else if (sleep_req_n_i) mode_d = PM_ACTIVE;
      end
      default: mode_d = PM_OFF;
    endcase
    if (por_i) mode_d = PM_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= PM_OFF;
    else        mode_q <= mode_d;
  end

  always_comb begin
    if (mode_q == PM_START)    en_vec_w = step_enables(step_idx_w);
    else if (mode_is_up(mode_q)) en_vec_w = '1;
    else                       en_vec_w = '0;
  end

  assign ref_en_o  = en_vec_w[0];
  assign osc_en_o  = en_vec_w[1];
  assign sup_en_o  = en_vec_w[2];
  assign reg_en_o  = en_vec_w[3];
  assign step_o    = (mode_q == PM_START) ? step_idx_w
                   : (mode_is_up(mode_q) ? STEP_W'(N_STEPS - 1) : '0);
  assign rst_rel_o = mode_is_up(mode_q);
  assign mode_o    = mode_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
module pwr_mode_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_i,
  input logic       uvp_i,
  input logic       ovp_i,
  input logic       cpu_tmo_i,
  input logic       wdog_fault_i,
  input logic       wake_w,
  input logic       ref_en_o,
  input logic       osc_en_o,
  input logic       sup_en_o,
  input logic       reg_en_o,
  input logic [1:0] step_o,
  input logic       rst_rel_o,
  input logic [1:0] mode_o
);

  // R1, R2: start-up is entered only from power-down on a wake event
  p_start_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && $past(mode_o) != 2'd1) |-> ($past(mode_o) == 2'd0 && $past(wake_w)));

  p_enable_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_o |-> ref_en_o) and (sup_en_o |-> osc_en_o) and (reg_en_o |-> sup_en_o));

  p_start_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && (uvp_i || ovp_i || cpu_tmo_i)) |=> (mode_o == 2'd0));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_rel_o) |-> (mode_o == 2'd2 && $past(mode_o) == 2'd1));

  p_sleep_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd3 && $past(mode_o) != 2'd3) |-> ($past(mode_o) == 2'd2));

  p_por_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (mode_o == 2'd0));

  p_active_trip_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && (wdog_fault_i || ovp_i)) |=> (mode_o == 2'd0));

  p_off_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |-> (!ref_en_o && !osc_en_o && !sup_en_o && !reg_en_o
                          && !rst_rel_o && step_o == 2'd0));

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .por_i        (por_i),
  .uvp_i        (uvp_i),
  .ovp_i        (ovp_i),
  .cpu_tmo_i    (cpu_tmo_i),
  .wdog_fault_i (wdog_fault_i),
  .wake_w       (wake_w),
  .ref_en_o     (ref_en_o),
  .osc_en_o     (osc_en_o),
  .sup_en_o     (sup_en_o),
  .reg_en_o     (reg_en_o),
  .step_o       (step_o),
  .rst_rel_o    (rst_rel_o),
  .mode_o       (mode_o)
);

// File: tb/pwr_mode_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_seq_tb_top;

  localparam int SC = 4;
  localparam int TM = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, por, chg, k1n, k2, rg_ref, rg_osc, rg_sup, rg_reg;
  logic uvp, ovp, tmo, slp_n, wdog;
  logic ref_en, osc_en, sup_en, reg_en, rel;
  logic [1:0] step, mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  pwr_mode_seq #(.STEP_CYC(SC), .TMIN(TM)) dut_i (
    .clk(clk), .rst_n(rst_n), .por_i(por), .chg_i(chg), .key1_n_i(k1n), .key2_i(k2),
    .ref_good_i(rg_ref), .osc_good_i(rg_osc), .sup_good_i(rg_sup), .reg_good_i(rg_reg),
    .uvp_i(uvp), .ovp_i(ovp), .cpu_tmo_i(tmo), .sleep_req_n_i(slp_n), .wdog_fault_i(wdog),
    .ref_en_o(ref_en), .osc_en_o(osc_en), .sup_en_o(sup_en), .reg_en_o(reg_en),
    .step_o(step), .rst_rel_o(rel), .mode_o(mode));

  // Reference model, built from the requirements
  int em, st, lowc;
  bit pp, pc, pk1, pk2;

  function automatic bit good_of(int k);
    case (k)
      0: return rg_ref;
      1: return rg_osc;
      2: return rg_sup;
      default: return rg_reg;
    endcase
  endfunction

  function automatic int exp_en();
    if (em == 1) return (1 << (st / SC + 1)) - 1;
    if (em >= 2) return 15;
    return 0;
  endfunction

  function automatic int exp_step();
    if (em == 1) return st / SC;
    if (em >= 2) return 3;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      em = 0; st = 0; lowc = 0; pp = 1; pc = 1; pk1 = 0; pk2 = 1;
    end else begin
      int nm;
      bit wk, flt;
      nm = em;
      wk = !por && ((pp && chg) || (chg && !pc) || (!k1n && pk1) || (k2 && !pk2));
      lowc = (em >= 2 && !rg_reg) ? lowc + 1 : 0;
      flt = lowc > TM;
      case (em)
        0: if (wk) begin nm = 1; st = 0; end
        1: begin
          if (uvp || ovp || tmo) nm = 0;
          else if ((st % SC) == SC - 1) begin
            if (!good_of(st / SC)) nm = 0;
            else if (st == 4 * SC - 1) nm = 2;
          end
          st = st + 1;
        end
        2: if (wdog || ovp || flt) nm = 0; else if (!slp_n) nm = 3;
        default: if (flt) nm = 0; else if (slp_n) nm = 2;
      endcase
      if (por) nm = 0;
      em = nm;
      pp = por; pc = chg; pk1 = k1n; pk2 = k2;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_cmp();
    check("R1 mode", int'(mode), em);
    check("R4 enables", int'({reg_en, sup_en, osc_en, ref_en}), exp_en());
    check("R7 release", int'(rel), (em >= 2) ? 1 : 0);
    check("R4 step", int'(step), exp_step());
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; por = 1; chg = 0; k1n = 1; k2 = 0;
    rg_ref = 1; rg_osc = 1; rg_sup = 1; rg_reg = 1;
    uvp = 0; ovp = 0; tmo = 0; slp_n = 1; wdog = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    check("R1 reset mode", mode, 0);
    check("R12 reset quiet", {reg_en, sup_en, osc_en, ref_en, rel}, 0);

    // Charger level at end of POR, then full start-up
    chg = 1; cyc();
    por = 0; cyc();
    check("R3 level wake", mode, 1);
    check("R4 step0 enables", {reg_en, sup_en, osc_en, ref_en}, 4'b0001);
    repeat (4) cyc();
    check("R4 step1 enables", {reg_en, sup_en, osc_en, ref_en}, 4'b0011);
    repeat (4) cyc();
    check("R4 step2 enables", {reg_en, sup_en, osc_en, ref_en}, 4'b0111);
    repeat (4) cyc();
    check("R4 step3 index", step, 3);
    repeat (3) cyc();
    check("R7 not yet", mode, 1);
    cyc();
    check("R7 active", mode, 2);
    check("R7 release", rel, 1);

    wdog = 1; cyc();
    check("R11 wdog off", mode, 0);
    wdog = 0;
    repeat (5) cyc();
    check("R3 steady charger ignored", mode, 0);

    // Main key falling edge, undervoltage abort
    k1n = 0; cyc();
    check("R2 key1 fall", mode, 1);
    uvp = 1; cyc();
    check("R6 uvp abort", mode, 0);
    uvp = 0; k1n = 1; cyc();
    check("R2 key1 rise ignored", mode, 0);
    check("R12 off quiet", {reg_en, sup_en, osc_en, ref_en, rel}, 0);

    // Second key, failing oscillator step
    k2 = 1; cyc();
    check("R2 key2 rise", mode, 1);
    rg_osc = 0;
    repeat (7) cyc();
    check("R5 before check", step, 1);
    cyc();
    check("R5 step fail", mode, 0);
    rg_osc = 1; k2 = 0; cyc();

    // Charger edge, processor timeout
    chg = 0; cyc();
    chg = 1; cyc();
    check("R2 charger rise", mode, 1);
    tmo = 1; cyc();
    check("R6 timeout abort", mode, 0);
    tmo = 0;

    // Power-on reset
    chg = 0; cyc();
    chg = 1; cyc();
    por = 1; cyc();
    check("R10 por off", mode, 0);
    k2 = 1; cyc();
    check("R10 wake held off", mode, 0);
    por = 0; cyc();
    check("R3 level wake after por", mode, 1);
    slp_n = 0;
    repeat (3) cyc();
    check("R8 sleep ignored in start", mode, 1);
    slp_n = 1;
    repeat (12) cyc();
    check("R7 still start", mode, 1);
    cyc();
    check("R7 active again", mode, 2);

    slp_n = 0; cyc();
    check("R8 enter sleep", mode, 3);
    check("R8 release held", rel, 1);
    slp_n = 1; cyc();
    check("R8 leave sleep", mode, 2);

    slp_n = 0; wdog = 1; cyc();
    check("R11 fault beats sleep", mode, 0);
    slp_n = 1; wdog = 0;

    // Regulator filter
    k2 = 0; cyc();
    k2 = 1; cyc();
    repeat (16) cyc();
    check("R9 up", mode, 2);
    rg_reg = 0;
    repeat (TM) cyc();
    check("R9 tolerated", mode, 2);
    cyc();
    check("R9 filter trip", mode, 0);
    rg_reg = 1;

    // Overvoltage in active
    k2 = 0; cyc();
    k2 = 1; cyc();
    repeat (16) cyc();
    ovp = 1; cyc();
    check("R11 ovp off", mode, 0);
    ovp = 0;

    // Constrained random phase
    for (int i = 0; i < 4000; i++) begin
      por    = ($urandom % 300) == 0;
      if (($urandom % 20) == 0) chg = ~chg;
      if (($urandom % 30) == 0) k1n = ~k1n;
      if (($urandom % 30) == 0) k2 = ~k2;
      rg_ref = ($urandom % 60) != 0;
      rg_osc = ($urandom % 60) != 0;
      rg_sup = ($urandom % 60) != 0;
      if (($urandom % 25) == 0) rg_reg = ~rg_reg;
      uvp    = ($urandom % 200) == 0;
      ovp    = ($urandom % 200) == 0;
      tmo    = ($urandom % 150) == 0;
      wdog   = ($urandom % 250) == 0;
      if (($urandom % 15) == 0) slp_n = ~slp_n;
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule